// File: doc/BRIEF.md
# MDIO Management Transaction Controller

This block lets a host run one management transaction at a time against an Ethernet PHY over the two-wire MDC/MDIO management interface. The host sees two 32-bit words: a command word and a data word. The command word holds a 5-bit PHY address, a 5-bit register number, a write flag and a start/busy flag. The data word holds the 16-bit value for a write, or the value returned by a read.

Setting the busy flag in the command word starts a transaction. The block then generates MDC from the system clock and shifts out a clause-22 frame, most significant bit first: 32 preamble ones, start code, opcode, PHY address, register number, turnaround and 16 data bits. The MDC divider is fixed when the design is elaborated, from the core-clock frequency parameter. A core clock below 20 MHz is rejected at elaboration. Software polls busy before and after each command.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, the command word and the data word both read 0, and MDC and the MDIO output enable are both low.
- R2: Writing the command word (host_sel = 0) with bit 0 set while idle starts a transaction. Bit 0 then reads back 1 until the frame completes and reads 0 afterwards. The command word layout is: PHY address in bits 15:11, register number in bits 10:6, write flag in bit 1, busy in bit 0, and all other bits read 0.
- R3: A write transaction (bit 1 = 1) sends 32 ones, then 01, then opcode 01, then the PHY address and register number MSB first, then turnaround 10, then the 16-bit data word MSB first. The output enable is held for all 64 bits.
- R4: A read transaction (bit 1 = 0) sends the same preamble and start code with opcode 10. The output enable is released for the last 18 bit times, which cover turnaround and data.
- R5: The MDIO output changes only at an MDC falling edge or at frame start (while MDC is low). Read data is sampled at MDC rising edges.
- R6: After a write, the data word (host_sel = 1, bits 15:0) still holds the written value. After a read, it holds the 16 sampled bits, with the first bit received in bit 15.
- R7: While busy is set, host writes to the command word and to the data word are ignored. The latched fields, the busy flag and the frame on the wire stay unchanged.
- R8: The MDC period in core-clock cycles is selected by core-clock band:
  - 16 for 20 to 35 MHz
  - 26 for 35 to 60 MHz
  - 42 for 60 to 100 MHz
  - 62 for 100 to 150 MHz
  - 102 for 150 MHz and above

  MDC is high for half of each period.
- R9: Whenever busy reads 0, MDC is low and the MDIO output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_sel | input | 1 | Word select: 0 = command word, 1 = data word |
| host_wdata | input | REG_W | Host write data |
| host_rdata | output | REG_W | Selected word, combinational read |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in from the PHY |

## Verification
The hardest situation to reach from the ports is a host write that arrives in the middle of a frame, while the shift register is partway through the frame. The stimulus issues a write command and, without waiting, rewrites both the command word and the data word with different values. It then checks three things: the command word still shows the original fields, the single expected frame appears on the wire, and the data word keeps the original value. For reads, a PHY model in the bench drives the return bits in step with MDC. This exercises the turnaround release and rising-edge sampling.

// File: rtl/mdio_mgmt_pkg.sv
`timescale 1ns/1ps
package mdio_mgmt_pkg;
   localparam int unsigned FRAME_BITS = 64;
   localparam int unsigned DATA_BITS  = 16;
   localparam int unsigned FIELD_W    = 5;
   localparam int unsigned BUSY_BIT   = 0;
   localparam int unsigned WRITE_BIT  = 1;
   localparam int unsigned REGNUM_LSB = 6;
   localparam int unsigned PHYADR_LSB = 11;

   typedef struct packed {
      logic [FIELD_W-1:0] phy;
      logic [FIELD_W-1:0] regnum;
      logic               wr;
   } mdio_cmd_t;

   // MDC period in core clocks, selected by core-clock band
   function automatic int unsigned mdc_period_for(input int unsigned hz);
      if (hz < 35_000_000)       return 16;
      else if (hz < 60_000_000)  return 26;
      else if (hz < 100_000_000) return 42;
      else if (hz < 150_000_000) return 62;
      else                       return 102;
   endfunction

   function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_cmd_t c,
                                                         input logic [DATA_BITS-1:0] d);
      logic [1:0] op, ta;
      op = c.wr ? 2'b01 : 2'b10;
      ta = c.wr ? 2'b10 : 2'b00;
      return {32'hFFFF_FFFF, 2'b01, op, c.phy, c.regnum, ta,
              (c.wr ? d : {DATA_BITS{1'b0}})};
   endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
`timescale 1ns/1ps
module mdio_mdc_gen #(
   parameter int unsigned DIV = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_tick,
   output logic fall_tick
);
   localparam int unsigned HALF = DIV / 2;
   localparam int unsigned CW   = $clog2(DIV);

   generate
      if ((DIV % 2) != 0 || DIV < 4) begin : g_bad_div
         $error("MDC period must be even and at least 4");
      end
   endgenerate

   logic [CW-1:0] cnt;

   assign rise_tick = run && (cnt == CW'(HALF - 1));
   assign fall_tick = run && (cnt == CW'(DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (!run) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else begin
         cnt <= fall_tick ? '0 : cnt + 1'b1;
         if (rise_tick)      mdc <= 1'b1;
         else if (fall_tick) mdc <= 1'b0;
      end
   end

   // R8: MDC only rises when the count crosses the half period
   assert_rise_at_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdc) |-> $past(cnt) == CW'(HALF - 1));

   // R9: a stopped divider parks MDC low
   assert_park_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !mdc);
endmodule

// File: rtl/mdio_frame_engine.sv
`timescale 1ns/1ps
module mdio_frame_engine #(
   parameter int unsigned FRAME_BITS = 64,
   parameter int unsigned DATA_BITS  = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [FRAME_BITS-1:0] frame_in,
   input  logic                  rd_mode,
   input  logic                  rise_tick,
   input  logic                  fall_tick,
   input  logic                  mdio_i,
   output logic                  active,
   output logic                  done,
   output logic                  mdio_o,
   output logic                  mdio_oe,
   output logic [DATA_BITS-1:0]  rd_data
);
   localparam int unsigned BW         = $clog2(FRAME_BITS);
   localparam int unsigned DATA_START = FRAME_BITS - DATA_BITS;
   localparam int unsigned TA_START   = DATA_START - 2;

   generate
      if (DATA_BITS + 2 >= FRAME_BITS) begin : g_bad_frame
         $error("frame too short for data and turnaround");
      end
   endgenerate

   logic [FRAME_BITS-1:0] shreg;
   logic [BW-1:0]         bitcnt;
   logic                  rd_q;

   assign mdio_o  = shreg[FRAME_BITS-1];
   assign done    = active && fall_tick && (bitcnt == BW'(FRAME_BITS - 1));
   assign mdio_oe = active && !(rd_q && (bitcnt >= BW'(TA_START)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg   <= '0;
         bitcnt  <= '0;
         rd_q    <= 1'b0;
         active  <= 1'b0;
         rd_data <= '0;
      end else if (load) begin
         shreg   <= frame_in;
         bitcnt  <= '0;
         rd_q    <= rd_mode;
         active  <= 1'b1;
      end else if (active) begin
         if (rise_tick && rd_q && (bitcnt >= BW'(DATA_START)))
            rd_data <= {rd_data[DATA_BITS-2:0], mdio_i};
         if (done) begin
            active <= 1'b0;
         end else if (fall_tick) begin
            shreg  <= {shreg[FRAME_BITS-2:0], 1'b0};
            bitcnt <= bitcnt + 1'b1;
         end
      end
   end

   // R5: between falling-edge ticks the driven bit holds
   assert_out_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      active && $past(active) && !$past(fall_tick) |-> $stable(mdio_o));

   // R2: a completed frame leaves the engine idle
   assert_done_stops_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !active);
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl
   import mdio_mgmt_pkg::*;
#(
   parameter int unsigned CORE_CLK_HZ = 25_000_000,
   parameter int unsigned REG_W       = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_wr,
   input  logic             host_sel,
   input  logic [REG_W-1:0] host_wdata,
   output logic [REG_W-1:0] host_rdata,
   output logic             mdc,
   output logic             mdio_o,
   output logic             mdio_oe,
   input  logic             mdio_i
);
   localparam int unsigned DIV = mdc_period_for(CORE_CLK_HZ);

   generate
      if (CORE_CLK_HZ < 20_000_000) begin : g_slow_core
         $error("core clock below 20 MHz is not supported");
      end
      if (REG_W < 16) begin : g_narrow_host
         $error("host word must be at least 16 bits");
      end
   endgenerate

   mdio_cmd_t            cmd_q;
   logic                 busy_q, start_q;
   logic [DATA_BITS-1:0] data_q, rd_data;
   logic                 eng_active, eng_done, rise_tick, fall_tick;
   logic [15:0]          cmd_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q   <= '0;
         busy_q  <= 1'b0;
         start_q <= 1'b0;
         data_q  <= '0;
      end else begin
         start_q <= 1'b0;
         if (eng_done) begin
            busy_q <= 1'b0;
            if (!cmd_q.wr) data_q <= rd_data;
         end else if (host_wr && !busy_q) begin
            if (!host_sel) begin
               cmd_q.phy    <= host_wdata[PHYADR_LSB +: FIELD_W];
               cmd_q.regnum <= host_wdata[REGNUM_LSB +: FIELD_W];
               cmd_q.wr     <= host_wdata[WRITE_BIT];
               if (host_wdata[BUSY_BIT]) begin
                  busy_q  <= 1'b1;
                  start_q <= 1'b1;
               end
            end else begin
               data_q <= host_wdata[DATA_BITS-1:0];
            end
         end
      end
   end

   assign cmd_word   = {cmd_q.phy, cmd_q.regnum, 4'b0000, cmd_q.wr, busy_q};
   assign host_rdata = host_sel ? REG_W'(data_q) : REG_W'(cmd_word);

   mdio_mdc_gen #(.DIV(DIV)) u_mdc (
      .clk(clk), .rst_n(rst_n), .run(eng_active),
      .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
   );

   mdio_frame_engine #(.FRAME_BITS(FRAME_BITS), .DATA_BITS(DATA_BITS)) u_eng (
      .clk(clk), .rst_n(rst_n), .load(start_q),
      .frame_in(build_frame(cmd_q, data_q)), .rd_mode(!cmd_q.wr),
      .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
      .active(eng_active), .done(eng_done),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_data(rd_data)
   );

   // R2: busy holds until the engine reports the end of the frame
   assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !eng_done |=> busy_q);

   // R7: host writes during a transaction leave the latched command alone
   assert_cmd_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && host_wr |=> $stable(cmd_q));

   // R7: the data word is untouched by host writes while busy
   assert_data_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && host_wr && !eng_done |=> $stable(data_q));

   // R9: idle means both pins parked
   assert_idle_pins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !mdio_oe && !mdc);
endmodule

// File: tb/mdio_mgmt_ctrl_test.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_test;
   localparam int unsigned CLK_HZ = 25_000_000;

   function automatic int unsigned exp_period(input int unsigned hz);
      if (hz >= 150_000_000) return 102;
      if (hz >= 100_000_000) return 62;
      if (hz >= 60_000_000)  return 42;
      if (hz >= 35_000_000)  return 26;
      return 16;
   endfunction

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        host_wr = 1'b0, host_sel = 1'b0;
   logic [31:0] host_wdata = '0, host_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b0;

   mdio_mgmt_ctrl #(.CORE_CLK_HZ(CLK_HZ), .REG_W(32)) uut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   always #2 clk = ~clk;

   int checks = 0, fails = 0, r5_bad = 0;
   longint cyc = 0;
   bit summary_done = 0;
   always @(posedge clk) cyc++;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!summary_done) begin
         summary_done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      end
   endtask

   typedef struct {
      logic [63:0] bits;
      logic [63:0] oe;
      logic [15:0] rd;
   } exp_t;
   exp_t exq[$];

   // R5: the data line may only move while MDC is low
   always @(mdio_o) if (rst_n && mdc === 1'b1) r5_bad++;

   // monitor: collects 64 rising-edge samples, plays the PHY for reads
   initial begin
      logic [63:0] got, goe;
      longint t0, t1;
      exp_t e;
      forever begin
         for (int k = 0; k < 64; k++) begin
            @(posedge mdc);
            if (k == 0) t0 = cyc;
            if (k == 1) t1 = cyc;
            got = {got[62:0], mdio_o};
            goe = {goe[62:0], mdio_oe};
            if (exq.size() > 0 && k >= 47 && k <= 62) mdio_i = exq[0].rd[62-k];
         end
         chk(t1 - t0 == longint'(exp_period(CLK_HZ)), "R8 mdc period",
             64'(t1 - t0), 64'(exp_period(CLK_HZ)));
         if (exq.size() == 0) begin
            chk(0, "R7 unexpected frame", got, 64'h0);
         end else begin
            e = exq.pop_front();
            chk(goe == e.oe, "R4 oe pattern", goe, e.oe);
            chk((got & e.oe) == (e.bits & e.oe), "R3 frame bits", got & e.oe, e.bits & e.oe);
         end
      end
   end

   task automatic host_write(input bit sel, input logic [31:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_sel = sel; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic host_read(input bit sel, output logic [31:0] d);
      @(negedge clk);
      host_sel = sel;
      #1 d = host_rdata;
   endtask

   function automatic logic [31:0] cmd_of(input logic [4:0] phy, input logic [4:0] rg,
                                          input bit wr, input bit go);
      return {16'h0, phy, rg, 4'b0, wr, go};
   endfunction

   task automatic start_txn(input logic [4:0] phy, input logic [4:0] rg, input bit wr,
                            input logic [15:0] wd, input logic [15:0] rv);
      exp_t e;
      e.bits = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg,
                (wr ? 2'b10 : 2'b00), (wr ? wd : 16'h0)};
      e.oe   = wr ? ~64'h0 : ~64'h3FFFF;
      e.rd   = rv;
      exq.push_back(e);
      if (wr) host_write(1'b1, {16'h0, wd});
      host_write(1'b0, cmd_of(phy, rg, wr, 1'b1));
   endtask

   task automatic wait_idle();
      logic [31:0] d;
      do host_read(1'b0, d); while (d[0]);
   endtask

   task automatic run_txn(input logic [4:0] phy, input logic [4:0] rg, input bit wr,
                          input logic [15:0] wd, input logic [15:0] rv);
      logic [31:0] d;
      start_txn(phy, rg, wr, wd, rv);
      host_read(1'b0, d);
      chk(d == cmd_of(phy, rg, wr, 1'b1), "R2 busy readback", d, cmd_of(phy, rg, wr, 1'b1));
      wait_idle();
      host_read(1'b0, d);
      chk(d == cmd_of(phy, rg, wr, 1'b0), "R2 busy cleared", d, cmd_of(phy, rg, wr, 1'b0));
      host_read(1'b1, d);
      chk(d == {16'h0, (wr ? wd : rv)}, "R6 data word", d, {16'h0, (wr ? wd : rv)});
      chk(mdc == 1'b0 && mdio_oe == 1'b0, "R9 idle pins", {mdc, mdio_oe}, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      // R1: reset state
      host_read(1'b0, d); chk(d == 0, "R1 command word", d, 0);
      host_read(1'b1, d); chk(d == 0, "R1 data word", d, 0);
      chk(mdc == 0 && mdio_oe == 0, "R1 pins", {mdc, mdio_oe}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      run_txn(5'd5,  5'd3,  1'b1, 16'hA5C3, 16'h0);
      run_txn(5'd31, 5'd0,  1'b0, 16'h0,    16'h1234);
      run_txn(5'd0,  5'd31, 1'b1, 16'h0000, 16'h0);
      run_txn(5'd10, 5'd21, 1'b0, 16'h0,    16'hFFFF);
      run_txn(5'd21, 5'd10, 1'b0, 16'h0,    16'h8001);

      // R7: rewrite both words mid-frame
      start_txn(5'd3, 5'd7, 1'b1, 16'h0F0F, 16'h0);
      repeat (40) @(negedge clk);
      host_write(1'b0, cmd_of(5'd9, 5'd2, 1'b0, 1'b1));
      host_write(1'b1, 32'h0000_DEAD);
      host_read(1'b0, d);
      chk(d == cmd_of(5'd3, 5'd7, 1'b1, 1'b1), "R7 command held", d, cmd_of(5'd3, 5'd7, 1'b1, 1'b1));
      host_read(1'b1, d);
      chk(d == 32'h0F0F, "R7 data held", d, 32'h0F0F);
      wait_idle();
      host_read(1'b1, d);
      chk(d == 32'h0F0F, "R6 R7 data after frame", d, 32'h0F0F);

      // R2: a command write without bit 0 updates fields but does not start
      host_write(1'b0, cmd_of(5'd1, 5'd2, 1'b1, 1'b0));
      repeat (40) @(negedge clk);
      host_read(1'b0, d);
      chk(d == cmd_of(5'd1, 5'd2, 1'b1, 1'b0), "R2 no start", d, cmd_of(5'd1, 5'd2, 1'b1, 1'b0));
      chk(mdc == 0 && mdio_oe == 0, "R9 pins after no-start", {mdc, mdio_oe}, 0);

      repeat (20) @(negedge clk);
      chk(exq.size() == 0, "R3 all frames seen", exq.size(), 0);
      chk(r5_bad == 0, "R5 mdio moved with mdc high", r5_bad, 0);
      summary();
      $finish;
   end
endmodule